// File: doc/BRIEF.md
# Dual-Channel Converter Code Update Controller

This block sits between a host register bus and two 12-bit analog output converters. Each channel has a holding register and an output register, so the code is buffered twice. The output register drives the converter. The host writes a code into a channel's holding register. A mode bit set by software decides when that code reaches the output register.

In immediate mode the output register takes the written code on the same clock edge that accepts the write. In delayed mode written codes wait in their holding registers and are marked pending. An update event then moves both channels to their outputs together. The update event comes from an active-low level on either of two inputs: an internal timer output or an external strobe pin. Both inputs are synchronized. Their combined low level fires once per falling edge, so a waveform can be stepped without glitches.

A mode state machine has two states, `MODE_IMM` and `MODE_DLY`:
- A mode write with `mode_in`=1 moves it to `MODE_DLY`.
- A mode write with `mode_in`=0 moves it to `MODE_IMM`.
- Entering `MODE_IMM` releases any pending codes.

A trigger state machine has two states, `TRG_ARMED` and `TRG_HELD`:
- `TRG_ARMED` goes to `TRG_HELD` when the synchronized combined level is low, and emits one update event on that transition.
- `TRG_HELD` returns to `TRG_ARMED` when the level is high again.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset both output codes are 0, both pending flags are 0 and the mode is immediate (`mode_delayed`=0).
- R2: In immediate mode, a write (`wr_en`=1, `wr_chan` 0 or 1 selecting channel 0 or 1) changes that channel's `code_out` to `wr_data` on the clock edge that samples the write. The full-scale code 0xFFF passes unchanged. The other channel is untouched and pending stays 0.
- R3: A mode write (`mode_wr`=1) with `mode_in`=1 selects delayed mode. In delayed mode a write leaves `code_out` unchanged and sets the channel's bit in `pending` (bit 0 is channel 0).
- R4: A low level on `timer_n` moves both holding registers to the outputs and clears both pending bits. This happens at the third rising edge after the input falls: two synchronizer stages, then the transfer edge.
- R5: A low level on `ext_update_n` gives the same transfer, with the same latency.
- R6: While the combined trigger level stays low, no further transfer happens. A rising trigger does not transfer. Only a new falling edge does.
- R7: If a write lands in the same cycle as an update event, the output takes the previous holding value. The channel stays pending, and the new code moves out on the next event.
- R8: A mode write with `mode_in`=0 while in delayed mode returns to immediate mode after that edge. Pending codes reach the outputs on the following edge, and pending clears.
- R9: In immediate mode, trigger activity has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Code write strobe |
| wr_chan | input | 1 | Channel select for the write |
| wr_data | input | 12 | Code to write |
| mode_wr | input | 1 | Mode register write strobe |
| mode_in | input | 1 | New mode: 1 delayed, 0 immediate |
| timer_n | input | 1 | Internal timer update request, active low |
| ext_update_n | input | 1 | External update strobe, active low |
| code_out | output | 2x12 | Output register codes, element i is channel i |
| pending | output | 2 | Per-channel pending flag |
| mode_delayed | output | 1 | Current mode, 1 when delayed |

## Verification
The hardest case to reach is a host write landing in exactly the cycle the update event fires, which lies three edges after the trigger falls. The bench drops the trigger on a falling clock edge, counts two rising edges and then presents the write, so the write and the transfer share one edge. A second hard case is a trigger held low across later writes: the bench keeps the line low, writes, waits, and then releases it, to show that neither the held level nor the rising edge transfers.

// File: rtl/dac_pkg.sv
package dac_pkg;
    typedef enum logic {
        MODE_IMM = 1'b0,
        MODE_DLY = 1'b1
    } mode_e;

    typedef enum logic {
        TRG_ARMED = 1'b0,
        TRG_HELD  = 1'b1
    } trg_e;
endpackage

// File: rtl/dac_trig_detect.sv
module dac_trig_detect
    import dac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic timer_n,
    input  logic ext_n,
    output logic fire
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_t;
    logic [SYNC_STAGES-1:0] sync_e;
    logic                   level_low;
    trg_e                   trg_q;
    trg_e                   trg_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_t <= '1;
            sync_e <= '1;
        end else begin
            sync_t <= {sync_t[SYNC_STAGES-2:0], timer_n};
            sync_e <= {sync_e[SYNC_STAGES-2:0], ext_n};
        end
    end

    assign level_low = !(sync_t[MSB] && sync_e[MSB]);

    always_ff @(posedge clk) begin
        if (!rst_n) trg_q <= TRG_ARMED;
        else        trg_q <= trg_d;
    end

    always_comb begin
        trg_d = trg_q;
        fire  = 1'b0;
        unique case (trg_q)
            TRG_ARMED: begin
                if (level_low) begin
                    trg_d = TRG_HELD;
                    fire  = 1'b1;
                end
            end
            TRG_HELD: begin
                if (!level_low) trg_d = TRG_ARMED;
            end
        endcase
    end

    // R6
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              imm,
    input  logic              fire,
    output logic [CODE_W-1:0] code,
    output logic              pend
);
    logic [CODE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            code   <= '0;
            pend   <= 1'b0;
        end else if (wr && imm) begin
            hold_q <= wr_data;
            code   <= wr_data;
            pend   <= 1'b0;
        end else if (wr) begin
            hold_q <= wr_data;
            pend   <= 1'b1;
            if (fire) code <= hold_q;
        end else if ((fire && !imm) || (imm && pend)) begin
            code <= hold_q;
            pend <= 1'b0;
        end
    end

    // R2
    imm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && imm) |=> (code == $past(wr_data)));
    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !imm) |=> pend);
    // R3
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm && !fire) |=> $stable(code));
    // R7
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !imm && fire) |=> (code == $past(hold_q)));
    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imm && pend) |=> !pend);
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_chan,
    input  logic [CODE_W-1:0]            wr_data,
    input  logic                         mode_wr,
    input  logic                         mode_in,
    input  logic                         timer_n,
    input  logic                         ext_update_n,
    output logic [NUM_CH-1:0][CODE_W-1:0] code_out,
    output logic [NUM_CH-1:0]            pending,
    output logic                         mode_delayed
);
    mode_e mode_q;
    mode_e mode_d;
    logic  imm;
    logic  fire;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_IMM;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_IMM: if (mode_wr && mode_in)  mode_d = MODE_DLY;
            MODE_DLY: if (mode_wr && !mode_in) mode_d = MODE_IMM;
        endcase
    end

    always_comb begin
        imm          = (mode_q == MODE_IMM);
        mode_delayed = (mode_q == MODE_DLY);
    end

    dac_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .timer_n (timer_n),
        .ext_n   (ext_update_n),
        .fire    (fire)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_hit;
        assign wr_hit = wr_en && (wr_chan == SEL_W'(i));

        dac_chan_reg #(.CODE_W(CODE_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_hit),
            .wr_data (wr_data),
            .imm     (imm),
            .fire    (fire),
            .code    (code_out[i]),
            .pend    (pending[i])
        );
    end

    // R9
    imm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imm && !wr_en && (pending == '0)) |=> $stable(code_out));
endmodule

// File: tb/test_dac_update_ctrl.sv
module test_dac_update_ctrl;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [0:0]       wr_chan = 1'b0;
    logic [11:0]      wr_data = '0;
    logic             mode_wr = 1'b0;
    logic             mode_in = 1'b0;
    logic             timer_n = 1'b1;
    logic             ext_update_n = 1'b1;
    logic [1:0][11:0] code_out;
    logic [1:0]       pending;
    logic             mode_delayed;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dac_update_ctrl i_dac_update_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_data(wr_data), .mode_wr(mode_wr), .mode_in(mode_in),
        .timer_n(timer_n), .ext_update_n(ext_update_n),
        .code_out(code_out), .pending(pending), .mode_delayed(mode_delayed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic ch, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = ch; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode_wr = 1'b1; mode_in = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 code0", code_out[0], 0);
        check("R1 code1", code_out[1], 0);
        check("R1 pending", pending, 0);
        check("R1 mode", mode_delayed, 0);
    endtask

    task automatic t_immediate;
        write(1'b0, 12'h5A3);
        check("R2 code0", code_out[0], 12'h5A3);
        check("R2 code1 untouched", code_out[1], 0);
        write(1'b1, 12'hFFF);
        check("R2 full scale code1", code_out[1], 12'hFFF);
        check("R2 pending", pending, 0);
    endtask

    task automatic t_imm_trigger;
        @(negedge clk); timer_n = 1'b0;
        idle(4);
        check("R9 code0", code_out[0], 12'h5A3);
        check("R9 code1", code_out[1], 12'hFFF);
        timer_n = 1'b1;
        idle(4);
    endtask

    task automatic t_delayed;
        set_mode(1'b1);
        check("R3 mode", mode_delayed, 1);
        write(1'b0, 12'h123);
        write(1'b1, 12'h456);
        check("R3 code0 held", code_out[0], 12'h5A3);
        check("R3 code1 held", code_out[1], 12'hFFF);
        check("R3 pending", pending, 2'b11);
    endtask

    task automatic t_timer;
        @(negedge clk); timer_n = 1'b0;
        idle(2);
        check("R4 latency code0", code_out[0], 12'h5A3);
        idle(1);
        check("R4 code0", code_out[0], 12'h123);
        check("R4 code1", code_out[1], 12'h456);
        check("R4 pending", pending, 0);
    endtask

    task automatic t_held;
        write(1'b0, 12'h321);
        idle(4);
        check("R6 held low code0", code_out[0], 12'h123);
        check("R6 held low pending", pending, 2'b01);
        timer_n = 1'b1;
        idle(5);
        check("R6 rising code0", code_out[0], 12'h123);
    endtask

    task automatic t_ext;
        @(negedge clk); ext_update_n = 1'b0;
        idle(3);
        check("R5 code0", code_out[0], 12'h321);
        check("R5 pending", pending, 0);
        ext_update_n = 1'b1;
        idle(4);
    endtask

    task automatic t_coincide;
        write(1'b1, 12'h0AA);
        @(negedge clk); ext_update_n = 1'b0;
        idle(2);
        wr_en = 1'b1; wr_chan = 1'b1; wr_data = 12'h0BB;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 code1 prior", code_out[1], 12'h0AA);
        check("R7 pending kept", pending, 2'b10);
        ext_update_n = 1'b1;
        idle(4);
        timer_n = 1'b0;
        idle(3);
        check("R7 code1 next", code_out[1], 12'h0BB);
        check("R7 pending cleared", pending, 0);
        timer_n = 1'b1;
        idle(4);
    endtask

    task automatic t_flush;
        write(1'b0, 12'h777);
        check("R8 pending before", pending, 2'b01);
        @(negedge clk);
        mode_wr = 1'b1; mode_in = 1'b0;
        @(negedge clk);
        mode_wr = 1'b0;
        check("R8 mode", mode_delayed, 0);
        check("R8 code0 not yet", code_out[0], 12'h321);
        @(negedge clk);
        check("R8 code0 flushed", code_out[0], 12'h777);
        check("R8 pending", pending, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_imm_trigger();
        t_delayed();
        t_timer();
        t_held();
        t_ext();
        t_coincide();
        t_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule